// File: doc/BRIEF.md
# Peripheral-to-Memory Receive DMA Channel

This block is one DMA channel that drains a serial receiver. Software programs four settings while the channel is off: the fixed address of the peripheral data register, a memory start address, a byte count, and a control word. The control word carries the interrupt enables, the transfer direction and a two-bit priority. The enable bit is set last. After that, every receive-not-empty request from the peripheral moves one byte. The channel reads the peripheral register and writes the byte to the current memory address in the same cycle. It then advances the memory address and lowers the remaining count.

When the last programmed byte has moved, the channel returns a one-cycle end-of-transfer pulse to the peripheral. The peripheral can use it to decide, for example, that the next byte is a checksum or that a NACK is due. An interrupt pulse can be requested at the halfway point, at the end, or at both. The priority field is presented on a port for an arbiter outside the block.

Top module: `rxdma_chan`

## Requirements
- R1: Configuration writes use `cfgAddr`. Register 0 is control: bit 0 enable, bit 1 half interrupt enable, bit 2 full interrupt enable, bit 3 direction, bits 5:4 priority. Register 1 is the peripheral address, register 2 the memory start address and register 3 the byte count. While the channel is enabled, writes to registers 1 to 3 are ignored, and a control write with bit 0 set is ignored.
- R2: No transfer happens before a control write sets the enable bit. That write loads the remaining count from register 3 and the current memory address from register 2, and both show from the next cycle.
- R3: An accepted request raises `perRdEn` and `memWrEn` in the same cycle. In that cycle `perRdAddr` equals register 1, `memWrAddr` equals the current memory address and `memWrData` equals `perRdData`.
- R4: After each accepted request the memory address rises by one, wrapping at its width, and `xferLeft` falls by one. The peripheral address does not change.
- R5: When a transfer takes `xferLeft` from 1 to 0, `eotPulse` is high for exactly the next cycle.
- R6: With the half enable set, `irq` pulses in the cycle after the transfer that leaves the remaining count equal to the programmed count divided by two, rounded down.
- R7: With the full enable set, `irq` pulses in the same cycle as `eotPulse`. When the half and full events fall on the same transfer, this gives a single pulse.
- R8: A request has no effect when the channel is disabled, when the remaining count is zero, or when the direction bit is 1.
- R9: `chanPrio` shows the priority field last stored in control.
- R10: A control write with bit 0 clear stops the channel at once. Enabling it again reloads the count and the start address from the stored registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register select |
| cfgWrData | input | REG_W | Configuration write data |
| rxReq | input | 1 | Receive-not-empty request from the peripheral |
| perRdData | input | 8 | Byte read from the peripheral register |
| perRdEn | output | 1 | Peripheral read strobe |
| perRdAddr | output | ADDR_W | Peripheral register address |
| memWrEn | output | 1 | Memory write strobe |
| memWrAddr | output | ADDR_W | Memory write address |
| memWrData | output | 8 | Memory write byte |
| eotPulse | output | 1 | End-of-transfer pulse to the peripheral |
| irq | output | 1 | Interrupt pulse |
| chanPrio | output | 2 | Channel priority for an outside arbiter |
| xferLeft | output | CNT_W | Remaining byte count |

## Verification
The read and write strobes, addresses and data are combinational results of a request, so they are due in the same cycle as `rxReq`. The count, the memory address, `eotPulse` and `irq` are due one cycle after the accepting edge. The bench drives every input just after a rising edge and samples on the falling edge. A behavioural model updates at each rising edge and, at every falling edge, predicts all outputs for the cycle then in progress. The prediction and the design therefore always refer to the same cycle, which includes back-to-back requests, the wrap of the address, and the case where the half and full events fall on the same transfer.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  // configuration register select values
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_PER  = 2'd1;
  localparam logic [1:0] REG_MEM  = 2'd2;
  localparam logic [1:0] REG_CNT  = 2'd3;

  // control word bit positions
  localparam int BIT_EN     = 0;
  localparam int BIT_HALFIE = 1;
  localparam int BIT_FULLIE = 2;
  localparam int BIT_DIR    = 3;
  localparam int BIT_PRIO   = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } dpStb_t;
endpackage

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [REG_W-1:0]  cfgWrData,
  input  logic              rxReq,
  input  logic              remZero,
  input  logic              remOne,
  input  logic              halfNext,
  output dpStb_t            stb,
  output logic [ADDR_W-1:0] perAddr,
  output logic [ADDR_W-1:0] memBase,
  output logic [CNT_W-1:0]  progCnt,
  output logic [1:0]        prio,
  output logic              eotPulse,
  output logic              irq
);
  logic enBit, dirBit, halfIe, fullIe;
  logic [1:0] prioR;
  logic [ADDR_W-1:0] perAddrR, memBaseR;
  logic [CNT_W-1:0] progCntR;
  logic eotR, irqR;
  logic ctrlWr, enabling, accept;

  assign ctrlWr   = cfgWrEn && (cfgAddr == REG_CTRL);
  assign enabling = ctrlWr && !enBit && cfgWrData[BIT_EN];
  assign accept   = rxReq && enBit && !dirBit && !remZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit  <= 1'b0;
      dirBit <= 1'b0;
      halfIe <= 1'b0;
      fullIe <= 1'b0;
      prioR  <= '0;
    end else if (ctrlWr) begin
      if (!enBit) begin
        enBit  <= cfgWrData[BIT_EN];
        halfIe <= cfgWrData[BIT_HALFIE];
        fullIe <= cfgWrData[BIT_FULLIE];
        dirBit <= cfgWrData[BIT_DIR];
        prioR  <= cfgWrData[BIT_PRIO +: 2];
      end else if (!cfgWrData[BIT_EN]) begin
        enBit <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perAddrR <= '0;
      memBaseR <= '0;
      progCntR <= '0;
    end else if (cfgWrEn && !enBit) begin
      case (cfgAddr)
        REG_PER: perAddrR <= cfgWrData[ADDR_W-1:0];
        REG_MEM: memBaseR <= cfgWrData[ADDR_W-1:0];
        REG_CNT: progCntR <= cfgWrData[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eotR <= 1'b0;
      irqR <= 1'b0;
    end else begin
      eotR <= accept && remOne;
      irqR <= accept && ((halfIe && halfNext) || (fullIe && remOne));
    end
  end

  always_comb begin
    stb.load = enabling;
    stb.step = accept;
  end

  assign perAddr  = perAddrR;
  assign memBase  = memBaseR;
  assign progCnt  = progCntR;
  assign prio     = prioR;
  assign eotPulse = eotR;
  assign irq      = irqR;

  // R5: end-of-transfer never lasts beyond one cycle
  p_eot_one_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    eotR |=> !eotR);

  // R1: addresses and count frozen while running
  p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && cfgWrEn && cfgAddr != REG_CTRL) |=>
      ($stable(perAddrR) && $stable(memBaseR) && $stable(progCntR)));

  // R6: an interrupt always follows an accepted transfer
  p_irq_after_xfer_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqR |-> $past(accept));

  // R8: nothing is accepted while the direction bit is set
  p_dir_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    dirBit |-> !stb.step);
endmodule

// File: rtl/rxdma_dpath.sv
module rxdma_dpath
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStb_t            stb,
  input  logic [ADDR_W-1:0] memBase,
  input  logic [CNT_W-1:0]  progCnt,
  output logic [ADDR_W-1:0] curMem,
  output logic [CNT_W-1:0]  remCnt,
  output logic              remZero,
  output logic              remOne,
  output logic              halfNext
);
  logic [ADDR_W-1:0] curMemR;
  logic [CNT_W-1:0] remCntR, halfMark;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMemR  <= '0;
      remCntR  <= '0;
      halfMark <= '0;
    end else if (stb.load) begin
      curMemR  <= memBase;
      remCntR  <= progCnt;
      halfMark <= progCnt >> 1;
    end else if (stb.step) begin
      curMemR <= curMemR + ADDR_W'(1);
      remCntR <= remCntR - CNT_W'(1);
    end
  end

  assign curMem   = curMemR;
  assign remCnt   = remCntR;
  assign remZero  = (remCntR == '0);
  assign remOne   = (remCntR == CNT_W'(1));
  assign halfNext = ((remCntR - CNT_W'(1)) == halfMark);

  // R4: count falls by one per transfer
  p_count_dec_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> remCntR == $past(remCntR) - CNT_W'(1));

  // R4: address rises by one per transfer
  p_mem_inc_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> curMemR == $past(curMemR) + ADDR_W'(1));

  // R8: control never steps an exhausted count
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |-> !remZero);

  // R8: a drained count stays drained until reloaded
  p_zero_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (remZero && !stb.load) |=> remZero);
endmodule

// File: rtl/rxdma_chan.sv
module rxdma_chan
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  localparam int REG_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [REG_W-1:0]  cfgWrData,
  input  logic              rxReq,
  input  logic [7:0]        perRdData,
  output logic              perRdEn,
  output logic [ADDR_W-1:0] perRdAddr,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [7:0]        memWrData,
  output logic              eotPulse,
  output logic              irq,
  output logic [1:0]        chanPrio,
  output logic [CNT_W-1:0]  xferLeft
);
  dpStb_t stb;
  logic [ADDR_W-1:0] perAddr, memBase, curMem;
  logic [CNT_W-1:0] progCnt, remCnt;
  logic remZero, remOne, halfNext;

  rxdma_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .rxReq(rxReq), .remZero(remZero),
    .remOne(remOne), .halfNext(halfNext), .stb(stb), .perAddr(perAddr),
    .memBase(memBase), .progCnt(progCnt), .prio(chanPrio),
    .eotPulse(eotPulse), .irq(irq)
  );

  rxdma_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .memBase(memBase),
    .progCnt(progCnt), .curMem(curMem), .remCnt(remCnt),
    .remZero(remZero), .remOne(remOne), .halfNext(halfNext)
  );

  assign perRdEn   = stb.step;
  assign perRdAddr = perAddr;
  assign memWrEn   = stb.step;
  assign memWrAddr = curMem;
  assign memWrData = perRdData;
  assign xferLeft  = remCnt;

  // R3: write and read strobes travel together
  p_strobes_paired_r3: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn == perRdEn);

  // R10: a step never coincides with a reload
  p_no_load_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.load && stb.step));
endmodule

// File: tb/test_rxdma_chan.sv
module test_rxdma_chan;
  localparam int AW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [15:0] cfgWrData = '0;
  logic rxReq = 1'b0;
  logic [7:0] perRdData = 8'h11;
  logic perRdEn, memWrEn, eotPulse, irq;
  logic [AW-1:0] perRdAddr, memWrAddr;
  logic [7:0] memWrData;
  logic [1:0] chanPrio;
  logic [CW-1:0] xferLeft;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  rxdma_chan #(.ADDR_W(AW), .CNT_W(CW)) i_rxdma_chan (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .rxReq(rxReq), .perRdData(perRdData),
    .perRdEn(perRdEn), .perRdAddr(perRdAddr), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .eotPulse(eotPulse),
    .irq(irq), .chanPrio(chanPrio), .xferLeft(xferLeft)
  );

  always #5 clk = ~clk;

  // behavioural reference state
  bit mEn, mDir, mHie, mFie, mEot, mIrq;
  int mPrio, mPer, mBase, mCnt, mRem, mCur, mHalf;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  function automatic bit accepted();
    return rxReq && mEn && !mDir && mRem != 0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    perRdData <= perRdData + 8'd37;
    if (!rstN) begin
      mEn = 0; mDir = 0; mHie = 0; mFie = 0; mEot = 0; mIrq = 0;
      mPrio = 0; mPer = 0; mBase = 0; mCnt = 0; mRem = 0; mCur = 0; mHalf = 0;
    end else begin
      bit acc;
      acc = accepted();
      mEot = acc && mRem == 1;
      mIrq = acc && ((mHie && mRem - 1 == mHalf) || (mFie && mRem == 1));
      if (acc) begin
        mRem = mRem - 1;
        mCur = (mCur + 1) % 65536;
      end
      if (cfgWrEn) begin
        if (cfgAddr == 2'd0) begin
          if (!mEn) begin
            mHie = cfgWrData[1]; mFie = cfgWrData[2];
            mDir = cfgWrData[3]; mPrio = cfgWrData[5:4];
            if (cfgWrData[0]) begin
              mEn = 1; mRem = mCnt; mCur = mBase; mHalf = mCnt / 2;
            end
          end else if (!cfgWrData[0]) begin
            mEn = 0;
          end
        end else if (!mEn) begin
          if (cfgAddr == 2'd1) mPer = cfgWrData;
          if (cfgAddr == 2'd2) mBase = cfgWrData;
          if (cfgAddr == 2'd3) mCnt = cfgWrData;
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      bit acc;
      acc = accepted();
      chk("R2 R3 R8 memWrEn", memWrEn, acc);
      chk("R3 R8 perRdEn", perRdEn, acc);
      if (acc) begin
        chk("R3 memWrAddr", memWrAddr, mCur);
        chk("R3 R4 perRdAddr", perRdAddr, mPer);
        chk("R3 memWrData", memWrData, perRdData);
      end
      chk("R5 eotPulse", eotPulse, mEot);
      chk("R6 R7 irq", irq, mIrq);
      chk("R4 xferLeft", xferLeft, mRem);
      chk("R9 chanPrio", chanPrio, mPrio);
    end else begin
      chk("R2 reset eotPulse", eotPulse, 0);
      chk("R2 reset xferLeft", xferLeft, 0);
    end
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(posedge clk); #1;
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
  endtask

  task automatic reqs(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rxReq = 1'b1;
      if (gap > 0) begin
        @(posedge clk); #1;
        rxReq = 1'b0;
        repeat (gap - 1) @(posedge clk);
      end
    end
    @(posedge clk); #1;
    rxReq = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R8 R2: requests before any enable
    reqs(3, 2);
    // R3 R4 R5 R6 R7: six bytes, both interrupts, priority 2
    wr(2'd1, 16'h0040);
    wr(2'd2, 16'h0100);
    wr(2'd3, 16'd6);
    wr(2'd0, 16'h0027);
    reqs(6, 3);
    // R8: count exhausted
    reqs(2, 2);
    wr(2'd0, 16'h0000);
    // R8: direction bit set
    wr(2'd3, 16'd4);
    wr(2'd0, 16'h0009);
    reqs(3, 2);
    wr(2'd0, 16'h0000);
    // R4: address wrap, back-to-back, priority 3, full only
    wr(2'd2, 16'hFFFE);
    wr(2'd3, 16'd5);
    wr(2'd0, 16'h0035);
    reqs(5, 0);
    wr(2'd0, 16'h0000);
    // R7: single byte, half and full coincide
    wr(2'd3, 16'd1);
    wr(2'd0, 16'h0007);
    reqs(1, 2);
    wr(2'd0, 16'h0000);
    // R1 R10: frozen config while running, then reload
    wr(2'd2, 16'h0020);
    wr(2'd3, 16'd7);
    wr(2'd0, 16'h0003);
    reqs(2, 2);
    wr(2'd3, 16'd2);
    wr(2'd2, 16'h0999);
    wr(2'd0, 16'h000B);
    reqs(1, 2);
    wr(2'd0, 16'h0000);
    reqs(1, 2);
    wr(2'd0, 16'h0003);
    @(negedge clk);
    chk("R1 R10 reload count", xferLeft, 7);
    reqs(7, 1);
    @(negedge clk);
    chk("R5 R10 drained", xferLeft, 0);
    repeat (4) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL all requirements: watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule